// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block turns the addressing fields of a memory-reference instruction into a 32-bit operand address. A request carries a 3-bit mode, a 3-bit register number, the operand size, the first extension word and a 32-bit displacement word. The block reads the selected base register and an index register through two combinational read ports. It writes an updated address register back for postincrement and predecrement. It returns the address, or a flag that the operand is a register, or a flag that the encoding is reserved.

Requests enter on a valid/ready port. The block takes a request only while it is idle, so `req_ready` low holds the requester off. The result stays on `res_*` with `res_valid` high until `res_ready` is seen high at a clock edge. For memory-indirect modes the block asks for a 32-bit pointer on a valid/ready read port. `mem_req_valid` and `mem_addr` hold steady until `mem_req_ready` is high. The reply is taken when `mem_rsp_valid` is high in a cycle where `mem_rsp_ready` is high. All address arithmetic wraps modulo 2^32.

Top module: `ea_gen`

## Requirements
- R1: Mode 000 (data register) and mode 001 (address register) return `res_is_reg`=1 and `res_addr`=0, with no writeback and no memory read.
- R2: Mode 010 returns the selected address register's value as the address.
- R3: Mode 011 returns the register's old value and writes back old+step. Mode 100 writes back old−step and returns that new value. Each is one writeback pulse.
- R4: The step is 1, 2 or 4 for `op_size` 00 (byte), 01 (word) or 10 (long). A byte step on register 7 is 2.
- R5: Mode 101 adds `ext_word`, sign-extended from 16 bits, to the address register.
- R6: Mode 110 with ext bit 8 = 0 is the short indexed form. Bit 15 picks the index file (0 data, 1 address) and bits 14:12 pick the register. Bit 11 = 0 sign-extends the low 16 bits of the index, and bit 11 = 1 uses all 32. Bits 10:9 scale the index by 1, 2, 4 or 8. Bits 7:0 are a signed displacement. The address is base + disp8 + scaled index.
- R7: Mode 110 with ext bit 8 = 1 is the full form. Bit 7 set removes the base term and bit 6 set removes the index term. Bits 5:4 select the base displacement: 01 none, 10 the low 16 bits of `disp_word` sign-extended, 11 all of `disp_word`. Bits 2:0 = 000 means no indirection.
- R8: Full form with bits 2:0 = 001 (pre-indexed) fetches a pointer at base+disp+index. The pointer is the address.
- R9: Full form with bits 2:0 = 010 (post-indexed) fetches a pointer at base+disp. The address is pointer+index.
- R10: The following raise `res_illegal` with address 0, no writeback and no memory read: `op_size` 11, mode 111, full form with bits 5:4 = 00, full form with bit 3 set, and full form with bits 2:0 above 010.
- R11: `req_ready` is high only while idle. `res_addr` and flags hold while `res_valid` waits for `res_ready`. `mem_addr` holds while `mem_req_valid` waits for `mem_req_ready`.
- R12: Address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting |
| req_mode | input | 3 | Addressing mode |
| req_reg | input | 3 | Register number |
| req_size | input | 2 | Operand size: 00 byte, 01 word, 10 long |
| req_ext | input | 16 | First extension word |
| req_disp | input | 32 | Displacement word |
| base_rd_sel | output | 3 | Address register read select |
| base_rd_data | input | 32 | Address register read value |
| idx_rd_sel | output | 4 | Index read select, bit 3 = address file |
| idx_rd_data | input | 32 | Index register read value |
| wb_en | output | 1 | Address register write strobe |
| wb_sel | output | 3 | Address register written |
| wb_data | output | 32 | Value written |
| mem_req_valid | output | 1 | Pointer read request |
| mem_req_ready | input | 1 | Pointer read accepted |
| mem_addr | output | 32 | Pointer location |
| mem_rsp_valid | input | 1 | Pointer data present |
| mem_rsp_ready | output | 1 | Block waiting for pointer |
| mem_rsp_data | input | 32 | Pointer value |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumed |
| res_addr | output | 32 | Effective address |
| res_is_reg | output | 1 | Operand is a register |
| res_illegal | output | 1 | Reserved encoding |

## Verification
The register modes are driven with values that differ from the result. This shows that a direct operand never leaks into the address and never causes a write. The step cases use byte, word and long sizes, with register 7 next to another register, so a missing stack-alignment rule shows up. The indexed cases use a negative 16-bit index, an address-register index at full width, several scales and negative displacements, which separates sign-extension errors from scale errors. The indirect cases use the same registers under pre- and post-indexing. An index added at the wrong point then moves both the pointer location and the final sum, and the two can be told apart.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int AW = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CALC, ST_FETCH, ST_WAIT, ST_DONE
  } ea_state_e;

  typedef struct packed {
    logic       idx_is_a;
    logic [2:0] idx_reg;
    logic       idx_long;
    logic [1:0] scale;
    logic       full;
    logic [7:0] d8;
    logic       base_sup;
    logic       idx_sup;
    logic [1:0] bd_size;
    logic       rsvd;
    logic [2:0] ind_sel;
  } ext_fields_t;

  localparam logic [2:0] M_DREG  = 3'd0;
  localparam logic [2:0] M_AREG  = 3'd1;
  localparam logic [2:0] M_IND   = 3'd2;
  localparam logic [2:0] M_POST  = 3'd3;
  localparam logic [2:0] M_PRE   = 3'd4;
  localparam logic [2:0] M_D16   = 3'd5;
  localparam logic [2:0] M_INDEX = 3'd6;
endpackage

// File: rtl/ea_ext_decode.sv
module ea_ext_decode
  import ea_pkg::*;
(
  input  logic [15:0]  ext,
  output ext_fields_t  f,
  output logic         ind_pre,
  output logic         ind_post,
  output logic         full_bad
);
  always_comb begin
    f.idx_is_a = ext[15];
    f.idx_reg  = ext[14:12];
    f.idx_long = ext[11];
    f.scale    = ext[10:9];
    f.full     = ext[8];
    f.d8       = ext[7:0];
    f.base_sup = ext[7];
    f.idx_sup  = ext[6];
    f.bd_size  = ext[5:4];
    f.rsvd     = ext[3];
    f.ind_sel  = ext[2:0];
  end

  assign ind_pre  = f.full && (f.ind_sel == 3'b001);
  assign ind_post = f.full && (f.ind_sel == 3'b010);
  assign full_bad = f.full && ((f.bd_size == 2'b00) || f.rsvd || (f.ind_sel > 3'b010));
endmodule

// File: rtl/ea_index.sv
module ea_index #(
  parameter int W = 32
) (
  input  logic [W-1:0] raw,
  input  logic         use_long,
  input  logic [1:0]   scale,
  input  logic         suppress,
  output logic [W-1:0] term
);
  localparam int HW = W / 2;
  logic [W-1:0] ext_val;

  assign ext_val = use_long ? raw : {{(W-HW){raw[HW-1]}}, raw[HW-1:0]};
  assign term    = suppress ? '0 : (ext_val << scale);
endmodule

// File: rtl/ea_step.sv
module ea_step #(
  parameter int W      = 32,
  parameter int SP_REG = 7
) (
  input  logic [1:0]   size,
  input  logic [2:0]   regn,
  output logic [W-1:0] step
);
  always_comb begin
    case (size)
      2'b00:   step = (regn == 3'(SP_REG)) ? W'(2) : W'(1);
      2'b01:   step = W'(2);
      default: step = W'(4);
    endcase
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int W = ea_pkg::AW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [2:0]   req_mode,
  input  logic [2:0]   req_reg,
  input  logic [1:0]   req_size,
  input  logic [15:0]  req_ext,
  input  logic [W-1:0] req_disp,
  output logic [2:0]   base_rd_sel,
  input  logic [W-1:0] base_rd_data,
  output logic [3:0]   idx_rd_sel,
  input  logic [W-1:0] idx_rd_data,
  output logic         wb_en,
  output logic [2:0]   wb_sel,
  output logic [W-1:0] wb_data,
  output logic         mem_req_valid,
  input  logic         mem_req_ready,
  output logic [W-1:0] mem_addr,
  input  logic         mem_rsp_valid,
  output logic         mem_rsp_ready,
  input  logic [W-1:0] mem_rsp_data,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_addr,
  output logic         res_is_reg,
  output logic         res_illegal
);
  localparam int HW = W / 2;

  ea_state_e    state_q, state_d;
  logic [2:0]   mode_q, reg_q;
  logic [1:0]   size_q;
  logic [15:0]  ext_q;
  logic [W-1:0] disp_q;
  logic [W-1:0] addr_q, idx_term_q;
  logic         isreg_q, illegal_q;

  ext_fields_t  f;
  logic         ind_pre, ind_post, full_bad;
  logic [W-1:0] scaled, step, bd, base_term;
  logic [W-1:0] calc_addr, calc_idx_keep;
  logic         calc_fetch, calc_illegal, calc_isreg;

  ea_ext_decode u_dec (
    .ext(ext_q), .f(f), .ind_pre(ind_pre), .ind_post(ind_post), .full_bad(full_bad)
  );

  ea_index #(.W(W)) u_idx (
    .raw(idx_rd_data), .use_long(f.idx_long), .scale(f.scale),
    .suppress(f.full && f.idx_sup), .term(scaled)
  );

  ea_step #(.W(W), .SP_REG(7)) u_step (
    .size(size_q), .regn(reg_q), .step(step)
  );

  assign base_rd_sel = reg_q;
  assign idx_rd_sel  = {f.idx_is_a, f.idx_reg};

  always_comb begin
    case (f.bd_size)
      2'b10:   bd = {{(W-HW){disp_q[HW-1]}}, disp_q[HW-1:0]};
      2'b11:   bd = disp_q;
      default: bd = '0;
    endcase
    base_term = (f.full && f.base_sup) ? '0 : base_rd_data;
  end

  always_comb begin
    calc_addr     = '0;
    calc_idx_keep = '0;
    calc_fetch    = 1'b0;
    calc_isreg    = 1'b0;
    calc_illegal  = (size_q == 2'b11) || (mode_q == 3'd7) ||
                    ((mode_q == M_INDEX) && full_bad);
    if (!calc_illegal) begin
      case (mode_q)
        M_DREG, M_AREG: calc_isreg = 1'b1;
        M_IND, M_POST:  calc_addr  = base_rd_data;
        M_PRE:          calc_addr  = base_rd_data - step;
        M_D16:          calc_addr  = base_rd_data + {{(W-16){ext_q[15]}}, ext_q};
        default: begin
          if (!f.full) begin
            calc_addr = base_rd_data + {{(W-8){f.d8[7]}}, f.d8} + scaled;
          end else if (ind_post) begin
            calc_addr     = base_term + bd;
            calc_idx_keep = scaled;
            calc_fetch    = 1'b1;
          end else begin
            calc_addr  = base_term + bd + scaled;
            calc_fetch = ind_pre;
          end
        end
      endcase
    end
  end

  assign wb_en   = (state_q == ST_CALC) && !calc_illegal &&
                   ((mode_q == M_POST) || (mode_q == M_PRE));
  assign wb_sel  = reg_q;
  assign wb_data = (mode_q == M_POST) ? base_rd_data + step : base_rd_data - step;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_CALC;
      ST_CALC:  state_d = calc_fetch ? ST_FETCH : ST_DONE;
      ST_FETCH: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) state_d = ST_DONE;
      ST_DONE:  if (res_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mode_q     <= '0;
      reg_q      <= '0;
      size_q     <= '0;
      ext_q      <= '0;
      disp_q     <= '0;
      addr_q     <= '0;
      idx_term_q <= '0;
      isreg_q    <= 1'b0;
      illegal_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          mode_q <= req_mode;
          reg_q  <= req_reg;
          size_q <= req_size;
          ext_q  <= req_ext;
          disp_q <= req_disp;
        end
        ST_CALC: begin
          addr_q     <= calc_addr;
          idx_term_q <= calc_idx_keep;
          isreg_q    <= calc_isreg;
          illegal_q  <= calc_illegal;
        end
        ST_WAIT: if (mem_rsp_valid) addr_q <= mem_rsp_data + idx_term_q;
        default: ;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_FETCH);
  assign mem_addr      = addr_q;
  assign mem_rsp_ready = (state_q == ST_WAIT);
  assign res_valid     = (state_q == ST_DONE);
  assign res_addr      = addr_q;
  assign res_is_reg    = isreg_q;
  assign res_illegal   = illegal_q;

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr) &&
                                $stable(res_is_reg) && $stable(res_illegal));
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));
  // R11
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_req_valid, mem_rsp_ready, res_valid}));
  // R3
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en && !mem_req_valid);
  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_illegal |-> res_addr == '0 && !res_is_reg);
  // R1
  reg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_is_reg |-> res_addr == '0);
endmodule

// File: tb/test_ea_gen.sv
module test_ea_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_mode = '0, req_reg = '0;
  logic [1:0]  req_size = '0;
  logic [15:0] req_ext = '0;
  logic [31:0] req_disp = '0;
  logic [2:0]  base_rd_sel;
  logic [31:0] base_rd_data;
  logic [3:0]  idx_rd_sel;
  logic [31:0] idx_rd_data;
  logic        wb_en;
  logic [2:0]  wb_sel;
  logic [31:0] wb_data;
  logic        mem_req_valid, mem_rsp_ready;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_addr, mem_rsp_data = '0;
  logic        res_valid, res_is_reg, res_illegal;
  logic        res_ready = 1'b0;
  logic [31:0] res_addr;

  logic [31:0] dr [8];
  logic [31:0] ar [8];
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign base_rd_data = ar[base_rd_sel];
  assign idx_rd_data  = idx_rd_sel[3] ? ar[idx_rd_sel[2:0]] : dr[idx_rd_sel[2:0]];

  ea_gen i_ea_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_reg(req_reg), .req_size(req_size),
    .req_ext(req_ext), .req_disp(req_disp),
    .base_rd_sel(base_rd_sel), .base_rd_data(base_rd_data),
    .idx_rd_sel(idx_rd_sel), .idx_rd_data(idx_rd_data),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr),
    .res_is_reg(res_is_reg), .res_illegal(res_illegal)
  );

  // Pointer memory: ready every other cycle, pointer = location + 0x0100_0000
  always @(posedge clk) begin
    mem_req_ready <= mem_req_valid ? ~mem_req_ready : 1'b0;
    if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem_addr + 32'h0100_0000;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Runs one request; hold = cycles res_ready is kept low after res_valid
  task automatic run(input logic [2:0] m, input logic [2:0] r, input logic [1:0] sz,
                     input logic [15:0] ext, input logic [31:0] disp, input int hold,
                     output logic [31:0] addr, output logic isreg, output logic ill,
                     output int nwb, output int nmem);
    bit pend = 0;
    logic [2:0] psel = '0;
    logic [31:0] pdat = '0;
    nwb = 0; nmem = 0;
    @(negedge clk);
    req_mode = m; req_reg = r; req_size = sz; req_ext = ext; req_disp = disp;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      if (pend) begin ar[psel] = pdat; pend = 0; end
      if (wb_en) begin pend = 1; psel = wb_sel; pdat = wb_data; nwb++; end
      if (mem_req_valid && mem_req_ready) nmem++;
      if (res_valid) break;
      @(negedge clk);
    end
    addr = res_addr; isreg = res_is_reg; ill = res_illegal;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R11 result held", {31'd0, res_valid}, 32'd1);
      chk("R11 address stable", res_addr, addr);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    if (pend) ar[psel] = pdat;
  endtask

  task automatic t_reset();
    chk("R11 reset req_ready", {31'd0, req_ready}, 32'd1);
    chk("R11 reset res_valid", {31'd0, res_valid}, 32'd0);
    chk("R11 reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    chk("R3 reset wb_en", {31'd0, wb_en}, 32'd0);
  endtask

  task automatic t_regmodes();
    logic [31:0] a; logic ir, il; int nw, nm;
    run(3'd0, 3'd2, 2'b10, 16'h0, 32'h0, 0, a, ir, il, nw, nm);
    chk("R1 data reg is_reg", {31'd0, ir}, 32'd1);
    chk("R1 data reg addr", a, 32'h0);
    run(3'd1, 3'd3, 2'b10, 16'h0, 32'h0, 0, a, ir, il, nw, nm);
    chk("R1 addr reg is_reg", {31'd0, ir}, 32'd1);
    chk("R1 addr reg no wb/mem", nw + nm, 32'd0);
    chk("R1 A3 untouched", ar[3], 32'h0001_2340);
  endtask

  task automatic t_indirect();
    logic [31:0] a; logic ir, il; int nw, nm;
    run(3'd2, 3'd3, 2'b01, 16'h0, 32'h0, 0, a, ir, il, nw, nm);
    chk("R2 (An) address", a, 32'h0001_2340);
    chk("R2 no writeback", nw, 32'd0);
  endtask

  task automatic t_step();
    logic [31:0] a; logic ir, il; int nw, nm;
    run(3'd3, 3'd2, 2'b10, 16'h0, 32'h0, 0, a, ir, il, nw, nm);
    chk("R3 postinc address old", a, 32'h0000_1000);
    chk("R3 postinc long A2", ar[2], 32'h0000_1004);
    chk("R3 one writeback", nw, 32'd1);
    run(3'd3, 3'd7, 2'b00, 16'h0, 32'h0, 0, a, ir, il, nw, nm);
    chk("R4 byte on A7 steps 2", ar[7], 32'h0000_2002);
    run(3'd3, 3'd1, 2'b00, 16'h0, 32'h0, 0, a, ir, il, nw, nm);
    chk("R4 byte on A1 steps 1", ar[1], 32'h0000_0501);
    run(3'd4, 3'd4, 2'b01, 16'h0, 32'h0, 0, a, ir, il, nw, nm);
    chk("R3 predec word address", a, 32'h0000_2FFE);
    chk("R4 predec word A4", ar[4], 32'h0000_2FFE);
    run(3'd4, 3'd7, 2'b00, 16'h0, 32'h0, 0, a, ir, il, nw, nm);
    chk("R4 predec byte A7", a, 32'h0000_2000);
  endtask

  task automatic t_d16();
    logic [31:0] a; logic ir, il; int nw, nm;
    run(3'd5, 3'd5, 2'b10, 16'hFFF0, 32'h0, 0, a, ir, il, nw, nm);
    chk("R5 negative d16", a, 32'h0000_7FF0);
    ar[5] = 32'hFFFF_FFF0;
    run(3'd5, 3'd5, 2'b10, 16'h0020, 32'h0, 0, a, ir, il, nw, nm);
    chk("R12 wrap on d16", a, 32'h0000_0010);
  endtask

  task automatic t_short();
    logic [31:0] a; logic ir, il; int nw, nm;
    run(3'd6, 3'd0, 2'b10, 16'h2410, 32'h0, 0, a, ir, il, nw, nm);
    chk("R6 word index sext x4", a, 32'h0000_1008);
    run(3'd6, 3'd0, 2'b10, 16'hEEFC, 32'h0, 0, a, ir, il, nw, nm);
    chk("R6 long A index x8 neg d8", a, 32'h0000_17FC);
  endtask

  task automatic t_full();
    logic [31:0] a; logic ir, il; int nw, nm;
    run(3'd6, 3'd0, 2'b10, 16'h1BB0, 32'h4000_0000, 0, a, ir, il, nw, nm);
    chk("R7 base suppressed bd32", a, 32'h4000_0020);
    run(3'd6, 3'd0, 2'b10, 16'h0160, 32'hABCD_8000, 0, a, ir, il, nw, nm);
    chk("R7 index suppressed bd16 sext", a, 32'hFFFF_9000);
    run(3'd6, 3'd0, 2'b10, 16'h0150, 32'h1234_5678, 0, a, ir, il, nw, nm);
    chk("R7 no bd, no index", a, 32'h0000_1000);
    chk("R7 no memory read", nm, 32'd0);
  endtask

  task automatic t_pre();
    logic [31:0] a; logic ir, il; int nw, nm;
    run(3'd6, 3'd0, 2'b10, 16'h1911, 32'h0, 2, a, ir, il, nw, nm);
    chk("R8 pre-indexed pointer", a, 32'h0100_1010);
    chk("R8 one memory read", nm, 32'd1);
  endtask

  task automatic t_post();
    logic [31:0] a; logic ir, il; int nw, nm;
    run(3'd6, 3'd0, 2'b10, 16'h1922, 32'h0000_0020, 0, a, ir, il, nw, nm);
    chk("R9 post-indexed address", a, 32'h0100_1030);
    chk("R9 one memory read", nm, 32'd1);
  endtask

  task automatic t_illegal();
    logic [31:0] a; logic ir, il; int nw, nm;
    run(3'd6, 3'd0, 2'b10, 16'h0100, 32'h0, 0, a, ir, il, nw, nm);
    chk("R10 bd size 00", {31'd0, il}, 32'd1);
    run(3'd6, 3'd0, 2'b10, 16'h0113, 32'h0, 0, a, ir, il, nw, nm);
    chk("R10 indirection 011", {31'd0, il}, 32'd1);
    chk("R10 no memory read", nm, 32'd0);
    run(3'd6, 3'd0, 2'b10, 16'h0118, 32'h0, 0, a, ir, il, nw, nm);
    chk("R10 reserved bit 3", {31'd0, il}, 32'd1);
    run(3'd7, 3'd0, 2'b10, 16'h0, 32'h0, 0, a, ir, il, nw, nm);
    chk("R10 mode 111", {31'd0, il}, 32'd1);
    run(3'd3, 3'd2, 2'b11, 16'h0, 32'h0, 3, a, ir, il, nw, nm);
    chk("R10 size 11 flagged", {31'd0, il}, 32'd1);
    chk("R10 size 11 address zero", a, 32'h0);
    chk("R10 size 11 A2 unchanged", ar[2], 32'h0000_1004);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin dr[i] = 32'h0; ar[i] = 32'h0; end
    ar[0] = 32'h0000_1000; ar[1] = 32'h0000_0500; ar[2] = 32'h0000_1000;
    ar[3] = 32'h0001_2340; ar[4] = 32'h0000_3000; ar[5] = 32'h0000_8000;
    ar[6] = 32'h0000_0100; ar[7] = 32'h0000_2000;
    dr[1] = 32'h0000_0010; dr[2] = 32'h0000_FFFE;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmodes();
    t_indirect();
    t_step();
    t_d16();
    t_short();
    t_full();
    t_pre();
    t_post();
    t_illegal();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule